// File: doc/BRIEF.md
# Two-Level Carry Lookahead Unit

This block is a combinational 16-bit carry lookahead generator. It takes a bit-wise generate vector, a bit-wise propagate vector and a carry-in. It returns the carry out of every bit position. It also returns a block-level generate and propagate pair, so that several units can sit under one more lookahead level. The operand bits are split into four groups of four. Each group resolves its internal carries with the fully expanded lookahead equations and reports a group generate and a group propagate.

A second lookahead stage uses the same expanded equations on the four group signals. It forms the carries at the group boundaries directly from the carry-in, so no carry ripples from one group to the next. The caller forms the per-bit signals as generate = a AND b and propagate = a XOR b. The caller forms each sum bit as propagate XOR the carry into that bit.

Top module: `cla_unit16`

## Requirements
- R1: For operands a, b with gen_i = a & b and prop_i = a ^ b, carry_o[k-1] (the carry into bit k, k = 1..16) equals bit k of the sum of the low k bits of a and b plus cin_i.
- R2: The sum prop_i ^ {carry_o[14:0], cin_i} equals (a + b + cin_i) mod 2^16, and carry_o[15] is the carry-out of that addition.
- R3: blk_gen_o is 1 exactly when the 16 bits produce a carry-out with a carry-in of 0, and when it is 1, carry_o[15] is 1 for either value of cin_i.
- R4: blk_prop_o is 1 exactly when every bit of prop_i is 1, and when it is 1, carry_o[15] equals cin_i.
- R5: When b is the bitwise complement of a, every bit of carry_o equals cin_i, for cin_i = 0 and cin_i = 1.
- R6: The boundary carries carry_o[3], [7], [11] and [15] come from the second lookahead stage. Each equals the carry that the group below would produce from its own carry-in. A carry generated in bit 0 is delivered correctly across all four groups.
- R7: Four units whose carry-ins come from the block generate and propagate of the units below (carry-in of unit k = G(k-1) | P(k-1) & carry-in of unit k-1) form a correct 64-bit adder.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| gen_i | input | 16 | Bit generate signals |
| prop_i | input | 16 | Bit propagate signals |
| cin_i | input | 1 | Carry into bit 0 |
| carry_o | output | 16 | Carry out of bit k in position k |
| blk_gen_o | output | 1 | Block generate over all 16 bits |
| blk_prop_o | output | 1 | Block propagate over all 16 bits |

## Verification
Random operand pairs cover the mix of generate, propagate and kill bits, and every carry is compared against a partial-sum reference. Complemented operand pairs make every bit propagate, so each carry must equal the carry-in and the block propagate must rise. This separates a correct skip path from one that drops the carry-in. A generate in bit 0 followed by an all-propagate run checks that the boundary carries really chain through the second stage. A 64-bit cascade of four units, including all-ones plus one, checks that the exported block generate and propagate compose correctly.

// File: rtl/cla_pkg.sv
package cla_pkg;
  localparam int unsigned DefGrpW  = 4;
  localparam int unsigned DefNumGrp = 4;
endpackage

// File: rtl/cla_lookahead.sv
module cla_lookahead #(
  parameter int unsigned N = 4
) (
  input  logic [N-1:0] g_i,
  input  logic [N-1:0] p_i,
  input  logic         c_i,
  output logic [N-1:0] c_o,
  output logic         g_o,
  output logic         p_o
);
  // expanded sum-of-products, no internal ripple
  always_comb begin
    for (int k = 0; k < N; k++) begin
      logic cy;
      logic term;
      cy = 1'b0;
      for (int j = 0; j <= k; j++) begin
        term = g_i[j];
        for (int m = j + 1; m <= k; m++) term = term & p_i[m];
        cy = cy | term;
      end
      term = c_i;
      for (int m = 0; m <= k; m++) term = term & p_i[m];
      c_o[k] = cy | term;
    end
  end

  always_comb begin
    logic acc;
    logic term;
    acc = 1'b0;
    for (int j = 0; j < N; j++) begin
      term = g_i[j];
      for (int m = j + 1; m < N; m++) term = term & p_i[m];
      acc = acc | term;
    end
    g_o = acc;
    p_o = &p_i;
  end

  always_comb begin
    // R4
    grp_prop_chk: assert (!p_o || (c_o[N-1] == c_i));
    // R3
    grp_gen_chk: assert (!g_o || c_o[N-1]);
  end
endmodule

// File: rtl/cla_unit16.sv
module cla_unit16
  import cla_pkg::*;
#(
  parameter int unsigned GRP_W   = DefGrpW,
  parameter int unsigned NUM_GRP = DefNumGrp
) (
  input  logic [GRP_W*NUM_GRP-1:0] gen_i,
  input  logic [GRP_W*NUM_GRP-1:0] prop_i,
  input  logic                     cin_i,
  output logic [GRP_W*NUM_GRP-1:0] carry_o,
  output logic                     blk_gen_o,
  output logic                     blk_prop_o
);
  localparam int unsigned W = GRP_W * NUM_GRP;

  logic [NUM_GRP-1:0] grp_g, grp_p, grp_cin, top_c;
  logic [GRP_W-1:0]   grp_c [NUM_GRP];

  // second level: group carries straight from cin_i
  cla_lookahead #(.N(NUM_GRP)) i_top (
    .g_i(grp_g), .p_i(grp_p), .c_i(cin_i),
    .c_o(top_c), .g_o(blk_gen_o), .p_o(blk_prop_o)
  );

  for (genvar gi = 0; gi < NUM_GRP; gi++) begin : g_grp
    if (gi == 0) begin : g_first
      assign grp_cin[gi] = cin_i;
    end else begin : g_rest
      assign grp_cin[gi] = top_c[gi-1];
    end

    cla_lookahead #(.N(GRP_W)) i_grp (
      .g_i(gen_i[gi*GRP_W +: GRP_W]), .p_i(prop_i[gi*GRP_W +: GRP_W]),
      .c_i(grp_cin[gi]),
      .c_o(grp_c[gi]), .g_o(grp_g[gi]), .p_o(grp_p[gi])
    );

    if (GRP_W > 1) begin : g_inner
      assign carry_o[gi*GRP_W +: GRP_W-1] = grp_c[gi][GRP_W-2:0];
    end
    assign carry_o[gi*GRP_W+GRP_W-1] = top_c[gi];

    always_comb begin
      // R6
      boundary_match_chk: assert (grp_c[gi][GRP_W-1] == top_c[gi]);
    end
  end

  always_comb begin
    // R3
    blk_gen_chk: assert (!blk_gen_o || carry_o[W-1]);
    // R4
    blk_prop_chk: assert (blk_prop_o == (&prop_i));
    // R5
    all_prop_chk: assert (!(&prop_i) || (carry_o == {W{cin_i}}));
  end
endmodule

// File: tb/test_cla_unit16.sv
module test_cla_unit16;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_err = 0;
  bit done = 1'b0;

  logic [15:0] a, b;
  logic        cin;
  logic [15:0] carry;
  logic        bg, bp;

  cla_unit16 i_cla_unit16 (
    .gen_i(a & b), .prop_i(a ^ b), .cin_i(cin),
    .carry_o(carry), .blk_gen_o(bg), .blk_prop_o(bp)
  );

  // 64-bit cascade of four units
  logic [63:0] xa, xb;
  logic        xcin;
  logic [15:0] xc [4];
  logic [3:0]  xg, xp;
  logic [3:0]  ucin;
  always_comb begin
    ucin[0] = xcin;
    for (int k = 1; k < 4; k++) ucin[k] = xg[k-1] | (xp[k-1] & ucin[k-1]);
  end
  for (genvar u = 0; u < 4; u++) begin : g_u
    cla_unit16 i_u (
      .gen_i(xa[u*16 +: 16] & xb[u*16 +: 16]), .prop_i(xa[u*16 +: 16] ^ xb[u*16 +: 16]),
      .cin_i(ucin[u]), .carry_o(xc[u]), .blk_gen_o(xg[u]), .blk_prop_o(xp[u])
    );
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [15:0] va, input logic [15:0] vb, input logic vc, input string tag);
    logic [16:0] full;
    logic [15:0] exp_c;
    logic [15:0] cvec;
    @(negedge clk);
    a = va; b = vb; cin = vc;
    #1;
    for (int k = 1; k <= 16; k++) begin
      logic [16:0] part;
      logic [16:0] mask;
      mask = (17'd1 << k) - 17'd1;
      part = ({1'b0, va} & mask) + ({1'b0, vb} & mask) + {16'd0, vc};
      exp_c[k-1] = part[k];
    end
    full = {1'b0, va} + {1'b0, vb} + {16'd0, vc};
    cvec = {carry[14:0], cin};
    chk({"R1 carries ", tag}, {48'd0, carry}, {48'd0, exp_c});
    chk({"R2 sum ", tag}, {47'd0, carry[15], (a ^ b) ^ cvec}, {47'd0, full});
    chk({"R3 blk_gen ", tag}, {63'd0, bg}, {63'd0, (({1'b0, va} + {1'b0, vb}) >> 16) != 0});
    chk({"R4 blk_prop ", tag}, {63'd0, bp}, {63'd0, (va ^ vb) == 16'hffff});
    if (bg) chk({"R3 gen forces cout ", tag}, {63'd0, carry[15]}, 64'd1);
    if (bp) chk({"R4 prop passes cin ", tag}, {63'd0, carry[15]}, {63'd0, vc});
  endtask

  task automatic apply64(input logic [63:0] va, input logic [63:0] vb, input logic vc);
    logic [64:0] full;
    logic [63:0] cv;
    @(negedge clk);
    xa = va; xb = vb; xcin = vc;
    #1;
    cv = {xc[3][14:0], ucin[3], xc[2][14:0], ucin[2], xc[1][14:0], ucin[1], xc[0][14:0], ucin[0]};
    full = {1'b0, va} + {1'b0, vb} + {64'd0, vc};
    chk("R7 cascade sum", (va ^ vb) ^ cv, full[63:0]);
    chk("R7 cascade cout", {63'd0, xg[3] | (xp[3] & ucin[3])}, {63'd0, full[64]});
  endtask

  initial begin
    a = '0; b = '0; cin = 1'b0;
    xa = '0; xb = '0; xcin = 1'b0;
    @(negedge clk); #1;
    // idle state: zero operands give zero carries
    chk("R1 zero inputs", {48'd0, carry}, 64'd0);
    chk("R4 zero inputs prop", {63'd0, bp}, 64'd0);

    // R5: all-propagate, both carry-in values
    for (int i = 0; i < 200; i++) begin
      logic [15:0] r;
      r = (i < 2) ? (i == 0 ? 16'h0000 : 16'hffff) : 16'($urandom);
      for (int c = 0; c < 2; c++) begin
        apply(r, ~r, c[0], "allprop");
        chk("R5 every carry equals cin", {48'd0, carry}, {48'd0, {16{c[0]}}});
      end
    end

    // R6: generate at bit 0, propagate above it
    apply(16'h0001, 16'hffff, 1'b0, "chain");
    chk("R6 chain across groups", {48'd0, carry}, 64'h0000_0000_0000_ffff);
    apply(16'hffff, 16'hffff, 1'b0, "allgen");
    apply(16'h0fff, 16'hf001, 1'b0, "grpskip");
    chk("R6 boundary carries", {60'd0, carry[15], carry[11], carry[7], carry[3]}, 64'hf);

    // R1/R2: random mix, both carry-in values
    for (int i = 0; i < 20000; i++) apply(16'($urandom), 16'($urandom), 1'($urandom), "random");

    // R7: cascade
    apply64(64'hffff_ffff_ffff_ffff, 64'd0, 1'b1);
    apply64(64'hffff_ffff_ffff_ffff, 64'd1, 1'b0);
    apply64(64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 1'b0);
    for (int i = 0; i < 2000; i++)
      apply64({$urandom, $urandom}, {$urandom, $urandom}, 1'($urandom));

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_err);
    $finish;
  end
endmodule